// File: doc/BRIEF.md
# Sixteen-Lane Writemask Merge Unit

This block forms the 512-bit destination of a packed single-precision vector operation. It routes a 32-bit operand to each of sixteen lanes and passes these operands to an external per-lane arithmetic function. That function is attached through combinational ports. The block then takes the sixteen lane results back and combines them with the prior destination value under a 16-bit writemask.

Three controls decide what each lane receives:

- **Masking:** a lane whose mask bit is clear either keeps its old contents (merging) or is cleared (zeroing).
- **Mask disable:** a separate bit turns masking off, so that every lane is written.
- **Broadcast:** when broadcast is requested and the source came from memory, every lane computes on source element 0.

The block also gathers the invalid-operation and divide-by-zero flags from the lanes that are actually written. The destination and both flags are registered. They appear one cycle after a valid input, together with a single-cycle done pulse.

Top module: `vec_wmask_merge`

## Requirements
- R1: While reset is asserted and after its release, `dst` is zero, `flag_inv` and `flag_dbz` are low, and `done` is low.
- R2: `done` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: Lane j occupies bits 32*j+31 down to 32*j. Without broadcast (`bcast` low or `src_is_mem` low), `lane_opnd` lane j equals `src` lane j.
- R4: With `bcast` and `src_is_mem` both high, every lane of `lane_opnd` equals `src[31:0]`.
- R5: An enabled lane of `dst` takes the corresponding lane of `lane_res` from the valid cycle.
- R6: In merging mode (`zero_mode` low), a lane that is not enabled takes the corresponding lane of `old_dst`.
- R7: In zeroing mode (`zero_mode` high), a lane that is not enabled becomes zero.
- R8: When `mask_off` is high, all sixteen lanes are enabled, whatever `wmask` and `zero_mode` hold. When it is low, lane j is enabled exactly when `wmask[j]` is 1.
- R9: `flag_inv` and `flag_dbz` are the OR of `lane_inv` and `lane_dbz`, each taken over the enabled lanes only. Disabled lanes contribute nothing.
- R10: In a cycle without `in_valid`, `dst`, `flag_inv` and `flag_dbz` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set is valid this cycle |
| src | input | 512 | Source vector, 16 lanes of 32 bits |
| old_dst | input | 512 | Prior destination value |
| wmask | input | 16 | Writemask, bit j enables lane j |
| mask_off | input | 1 | Ignore the writemask; enable all lanes |
| zero_mode | input | 1 | 1: clear disabled lanes; 0: keep old value |
| bcast | input | 1 | Broadcast element 0 request |
| src_is_mem | input | 1 | Source came from memory |
| lane_opnd | output | 512 | Per-lane operands to the external function |
| lane_res | input | 512 | Per-lane results from the external function |
| lane_inv | input | 16 | Per-lane invalid flags from the external function |
| lane_dbz | input | 16 | Per-lane divide-by-zero flags from the external function |
| dst | output | 512 | Registered destination |
| flag_inv | output | 1 | Registered invalid flag over enabled lanes |
| flag_dbz | output | 1 | Registered divide-by-zero flag over enabled lanes |
| done | output | 1 | One-cycle pulse marking new `dst` and flags |

## Verification
The assertions assume two things about the external lane function:

- It is purely combinational.
- Its `lane_res`, `lane_inv` and `lane_dbz` are settled at the clock edge of a valid cycle.

The bench meets this with a combinational model driven from `lane_opnd`. All inputs change only on the falling edge.

Random stimulus covers every combination of the four mode bits. The mask is biased toward the all-zero and all-one patterns, so the fully merged, fully cleared and fully written destinations occur often. Idle cycles between vectors exercise the hold behaviour.

// File: rtl/wm_merge_pkg.sv
package wm_merge_pkg;
   // Fate of one destination lane for a valid input
   typedef enum logic [1:0] {
      LANE_WRITE = 2'd0,
      LANE_KEEP  = 2'd1,
      LANE_CLEAR = 2'd2
   } lane_fate_e;

   function automatic lane_fate_e fate_of(input logic en, input logic zero_mode);
      if (en)             return LANE_WRITE;
      else if (zero_mode) return LANE_CLEAR;
      else                return LANE_KEEP;
   endfunction
endpackage

// File: rtl/wm_operand_route.sv
module wm_operand_route #(
   parameter int LANES = 16,
   parameter int EW    = 32
) (
   input  logic [LANES*EW-1:0] src,
   input  logic                bcast_en,
   output logic [LANES*EW-1:0] opnd
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign opnd[j*EW +: EW] = bcast_en ? src[EW-1:0] : src[j*EW +: EW];
   end
endmodule

// File: rtl/wm_lane_enable.sv
module wm_lane_enable #(
   parameter int LANES = 16
) (
   input  logic [LANES-1:0] wmask,
   input  logic             mask_off,
   output logic [LANES-1:0] en
);
   assign en = mask_off ? {LANES{1'b1}} : wmask;
endmodule

// File: rtl/wm_lane_merge.sv
module wm_lane_merge
   import wm_merge_pkg::*;
#(
   parameter int LANES = 16,
   parameter int EW    = 32
) (
   input  logic [LANES*EW-1:0] res,
   input  logic [LANES*EW-1:0] old,
   input  logic [LANES-1:0]    en,
   input  logic                zero_mode,
   input  logic [LANES-1:0]    inv_in,
   input  logic [LANES-1:0]    dbz_in,
   output logic [LANES*EW-1:0] merged,
   output logic                inv_any,
   output logic                dbz_any
);
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      lane_fate_e fate;
      assign fate = fate_of(en[j], zero_mode);
      always_comb begin
         unique case (fate)
            LANE_WRITE: merged[j*EW +: EW] = res[j*EW +: EW];
            LANE_KEEP:  merged[j*EW +: EW] = old[j*EW +: EW];
            default:    merged[j*EW +: EW] = '0;
         endcase
      end
   end

   assign inv_any = |(inv_in & en);
   assign dbz_any = |(dbz_in & en);
endmodule

// File: rtl/vec_wmask_merge.sv
module vec_wmask_merge #(
   parameter int LANES = 16,
   parameter int EW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [511:0]     src,
   input  logic [511:0]     old_dst,
   input  logic [15:0]      wmask,
   input  logic             mask_off,
   input  logic             zero_mode,
   input  logic             bcast,
   input  logic             src_is_mem,
   output logic [511:0]     lane_opnd,
   input  logic [511:0]     lane_res,
   input  logic [15:0]      lane_inv,
   input  logic [15:0]      lane_dbz,
   output logic [511:0]     dst,
   output logic             flag_inv,
   output logic             flag_dbz,
   output logic             done
);
   localparam int VW = LANES * EW;

   if (LANES < 1 || EW < 1) begin : g_bad_shape
      $error("vec_wmask_merge: LANES and EW must be positive");
   end
   if (VW != 512 || LANES != 16) begin : g_bad_width
      $error("vec_wmask_merge: port widths fix LANES*EW=512 and LANES=16");
   end

   logic [LANES-1:0] en;
   logic [VW-1:0]    merged;
   logic             inv_any, dbz_any;

   wm_operand_route #(.LANES(LANES), .EW(EW)) i_route (
      .src      (src),
      .bcast_en (bcast & src_is_mem),
      .opnd     (lane_opnd)
   );

   wm_lane_enable #(.LANES(LANES)) i_enable (
      .wmask    (wmask),
      .mask_off (mask_off),
      .en       (en)
   );

   wm_lane_merge #(.LANES(LANES), .EW(EW)) i_merge (
      .res       (lane_res),
      .old       (old_dst),
      .en        (en),
      .zero_mode (zero_mode),
      .inv_in    (lane_inv),
      .dbz_in    (lane_dbz),
      .merged    (merged),
      .inv_any   (inv_any),
      .dbz_any   (dbz_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst      <= '0;
         flag_inv <= 1'b0;
         flag_dbz <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= in_valid;
         if (in_valid) begin
            dst      <= merged;
            flag_inv <= inv_any;
            flag_dbz <= dbz_any;
         end
      end
   end
endmodule

// File: rtl/vec_wmask_merge_chk.sv
module vec_wmask_merge_chk #(
   parameter int LANES = 16,
   parameter int EW    = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [511:0] src,
   input logic [511:0] old_dst,
   input logic [15:0]  wmask,
   input logic         mask_off,
   input logic         zero_mode,
   input logic         bcast,
   input logic         src_is_mem,
   input logic [511:0] lane_opnd,
   input logic [511:0] lane_res,
   input logic [15:0]  lane_inv,
   input logic [15:0]  lane_dbz,
   input logic [511:0] dst,
   input logic         flag_inv,
   input logic         flag_dbz,
   input logic         done
);
   localparam int VW = LANES * EW;

   // R2: done follows in_valid by one cycle
   a_r2_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);
   a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !done);

   // R3: top lane uses its own slice without broadcast
   a_r3_own_slice: assert property (@(posedge clk) disable iff (!rst_n)
      !(bcast && src_is_mem) |-> lane_opnd[VW-1 -: EW] == src[VW-1 -: EW]);

   // R4: top lane sees element 0 under broadcast
   a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast && src_is_mem) |-> lane_opnd[VW-1 -: EW] == src[EW-1:0]);

   // R6: merging with an empty mask returns the old destination
   a_r6_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mask_off && !zero_mode && wmask == '0) |=> dst == $past(old_dst));

   // R7 / R9: zeroing with an empty mask clears all lanes and all flags
   a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mask_off && zero_mode && wmask == '0) |=> (dst == '0 && !flag_inv && !flag_dbz));

   // R8 / R5: mask disabled writes every lane from the lane results
   a_r8_all_written: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_off) |=> dst == $past(lane_res));

   // R9: with all lanes enabled the flags are the plain OR
   a_r9_flags_all: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_off) |=> (flag_inv == $past(|lane_inv) && flag_dbz == $past(|lane_dbz)));

   // R10: outputs hold without a valid input
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(dst) && $stable(flag_inv) && $stable(flag_dbz)));
endmodule

bind vec_wmask_merge vec_wmask_merge_chk #(.LANES(LANES), .EW(EW)) i_chk (.*);

// File: tb/test_vec_wmask_merge.sv
module test_vec_wmask_merge;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [511:0] src = '0, old_dst = '0;
   logic [15:0]  wmask = '0;
   logic         mask_off = 1'b0, zero_mode = 1'b0, bcast = 1'b0, src_is_mem = 1'b0;
   logic [511:0] lane_opnd, lane_res, dst;
   logic [15:0]  lane_inv, lane_dbz;
   logic         flag_inv, flag_dbz, done;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   vec_wmask_merge i_vec_wmask_merge (.*);

   // Stand-in lane function
   function automatic logic [31:0] fres(input logic [31:0] op, input int j);
      return {op[15:0], op[31:16]} ^ (32'h0101_0101 * j);
   endfunction
   function automatic logic finv(input logic [31:0] op);
      return op[31];
   endfunction
   function automatic logic fdbz(input logic [31:0] op);
      return op[30:23] == 8'h00;
   endfunction

   always_comb begin
      for (int j = 0; j < 16; j++) begin
         lane_res[j*32 +: 32] = fres(lane_opnd[j*32 +: 32], j);
         lane_inv[j]          = finv(lane_opnd[j*32 +: 32]);
         lane_dbz[j]          = fdbz(lane_opnd[j*32 +: 32]);
      end
   end

   function automatic logic [31:0] exp_op(input int j);
      return (bcast && src_is_mem) ? src[31:0] : src[j*32 +: 32];
   endfunction
   function automatic logic exp_en(input int j);
      return mask_off || wmask[j];
   endfunction

   task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [511:0] s, input logic [511:0] o, input logic [15:0] m,
                        input logic moff, input logic zm, input logic bc, input logic mem);
      logic [511:0] e_op, e_dst;
      logic         e_inv, e_dbz;
      @(negedge clk);
      src = s; old_dst = o; wmask = m; mask_off = moff;
      zero_mode = zm; bcast = bc; src_is_mem = mem; in_valid = 1'b1;
      #1;
      e_inv = 1'b0; e_dbz = 1'b0;
      for (int j = 0; j < 16; j++) begin
         e_op[j*32 +: 32] = exp_op(j);
         if (exp_en(j)) begin
            e_dst[j*32 +: 32] = fres(exp_op(j), j);
            e_inv |= finv(exp_op(j));
            e_dbz |= fdbz(exp_op(j));
         end else begin
            e_dst[j*32 +: 32] = zm ? 32'h0 : o[j*32 +: 32];
         end
      end
      chk((bc && mem) ? "R4 operand" : "R3 operand", lane_opnd, e_op);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R5/R6/R7/R8 dst", dst, e_dst);
      chk("R9 flags", {510'b0, flag_inv, flag_dbz}, {510'b0, e_inv, e_dbz});
      chk("R2 done", {511'b0, done}, 512'b1);
      // idle cycle with changed inputs: outputs must hold
      src = ~src; old_dst = ~old_dst; wmask = ~wmask; zero_mode = ~zero_mode;
      @(negedge clk);
      chk("R10 hold dst", dst, e_dst);
      chk("R10 hold flags", {510'b0, flag_inv, flag_dbz}, {510'b0, e_inv, e_dbz});
      chk("R2 no done", {511'b0, done}, 512'b0);
   endtask

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [511:0] a, b;
      logic [15:0]  m;
      void'($urandom(32'd2718));
      repeat (2) @(negedge clk);
      // R1: reset state
      chk("R1 reset", {dst[508:0], flag_inv, flag_dbz, done}, 512'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {dst[508:0], flag_inv, flag_dbz, done}, 512'b0);

      a = rnd512(); b = rnd512();
      apply(a, b, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);   // R6 full merge
      apply(a, b, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);   // R7 full clear, flags none
      apply(a, b, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);   // R8 mask ignored
      apply(a, b, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0);   // R3 bcast without memory
      apply(a, b, 16'hA5C3, 1'b0, 1'b1, 1'b1, 1'b1);   // R4 broadcast
      // R9: only masked-off lanes raise flags
      a = '0;
      for (int j = 1; j < 16; j++) a[j*32 +: 32] = 32'h8000_0000;
      a[31:0] = 32'h3F80_0000;
      apply(a, b, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0);
      apply(a, b, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0);

      for (int n = 0; n < 300; n++) begin
         a = rnd512(); b = rnd512();
         case ($urandom % 4)
            0: m = 16'h0000;
            1: m = 16'hFFFF;
            default: m = 16'($urandom);
         endcase
         apply(a, b, m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule